// File: doc/BRIEF.md
# ADC Conversion Trigger and End-of-Conversion Sequencer

This block sits between the serial front end, the shared convert-start pin and the successive-approximation core of a 12-bit converter. It decides when a conversion run begins, issues one start pulse to the core for every conversion in the run, counts the operations still owed, and drives the active-low end-of-conversion line (`eoc_n`). Its behaviour is governed by a 2-bit clock-mode field written through a setup byte. The field selects where requests come from: a falling edge on the convert-start pin, or a write to the conversion register. It also selects how many conversions one request asks for, and whether `eoc_n` is ever driven low.

A control state machine holds three states. ST_IDLE waits for a request allowed by the current mode. On an accepted request it loads the operation counter and moves to ST_ISSUE. ST_ISSUE raises `core_start` for exactly one cycle, latches the result-format flag and moves to ST_WAIT. ST_WAIT waits for `core_done`. A done pulse with one operation left returns the machine to ST_IDLE and drives `eoc_n` low. A done pulse with more operations left returns it to ST_ISSUE. Requests that arrive outside ST_IDLE are dropped.

In the externally clocked mode the block still sequences single conversions requested over the serial interface, but it forces scanning and averaging off and keeps `eoc_n` high.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `eoc_n` is 1, `remaining` is 0, `core_start` is 0, `scan_active` is 0 and the clock mode is 2'b10, so a single conversion-register write runs one conversion.
- R2: A setup write loads the clock mode from `setup_byte[5:4]`, the scan request from bit 3 and the averaging request from bit 2; bits 7, 6, 1 and 0 have no effect.
- R3: In mode 2'b00, a falling edge on `cnvst_n` starts a run of `setup_len` conversions when scanning is on, and 1 when it is off; `eoc_n` stays high until the last conversion of the run is done.
- R4: In mode 2'b01, each falling edge on `cnvst_n` runs exactly one conversion, and `eoc_n` goes low after that conversion is done.
- R5: In mode 2'b10, a `conv_wr` pulse starts a run of `setup_len` conversions when scanning is on, and 1 when it is off; `eoc_n` goes low after the last one.
- R6: In mode 2'b11, `scan_active` and `avg_active` are 0 whatever was requested, a `conv_wr` pulse runs one conversion, and `eoc_n` is 1 from the cycle after the mode is in effect.
- R7: `conv_wr` is ignored in modes 2'b00 and 2'b01. `cnvst_n` edges start nothing in modes 2'b10 and 2'b11. Any request that arrives while a run is in progress is ignored.
- R8: `eoc_n` returns to 1 on the clock after `cs_n` is sampled low, and after a detected falling edge of `cnvst_n`, in every mode.
- R9: `remaining` shows the number of conversions of the current run not yet done. It is loaded when a run is accepted and drops by one on each `core_done`.
- R10: `result_twos` is set to 1 for a conversion whose `chan_temp` or `chan_bip_diff` input is 1 in its start cycle, and to 0 otherwise.
- R11: A programmed scan length of 0 is treated as a run of 1 conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_wr | input | 1 | Setup byte write strobe |
| setup_byte | input | 8 | Setup byte: [5:4] clock mode, [3] scan, [2] average |
| setup_len | input | LEN_W | Scan length, loaded with the setup byte |
| conv_wr | input | 1 | Conversion-register write strobe from the serial front end |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| cnvst_n | input | 1 | Convert-start pin, active low, asynchronous |
| chan_temp | input | 1 | Current conversion is a temperature reading |
| chan_bip_diff | input | 1 | Current conversion is bipolar differential |
| core_done | input | 1 | One-cycle done pulse from the SAR core |
| core_start | output | 1 | One-cycle start pulse to the SAR core |
| eoc_n | output | 1 | End of conversion, active low |
| remaining | output | LEN_W | Conversions left in the current run |
| scan_active | output | 1 | Scanning in effect after mode gating |
| avg_active | output | 1 | Averaging in effect after mode gating |
| result_twos | output | 1 | Latest result is two's complement |

## Verification
The bench goes after the end of a multi-conversion scan. A design that drove `eoc_n` low after every done pulse in mode 2'b00 would show a low `eoc_n` while `remaining` is still nonzero. A design that ignores the busy state is caught when a second convert-start edge lands mid-run and adds extra start pulses. Requests from the wrong source in each mode are checked against an unchanged start count, and a design that skips the mode gating would leave scanning on, or pull `eoc_n` low, in the externally clocked mode. A zero scan length, setup bytes with junk in the unused bits, and a low `cs_n` after completion cover the remaining edges of the behaviour.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        CM_PIN_SCAN   = 2'b00,
        CM_PIN_SINGLE = 2'b01,
        CM_SERIAL     = 2'b10,
        CM_EXT_CLK    = 2'b11
    } clk_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ISSUE = 2'b01,
        ST_WAIT  = 2'b10
    } seq_state_e;

    localparam int MODE_LSB = 4;
    localparam int SCAN_BIT = 3;
    localparam int AVG_BIT  = 2;

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[STAGES-1:0], pin_n};
    end

    assign fall = sh[STAGES] & ~sh[STAGES-1];

    // R8: a detected edge is a single-cycle event
    assert_fall_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/adc_seq_cnt.sv
module adc_seq_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= load_val;
        else if (dec)  cnt <= cnt - W'(1);
    end

    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt != '0));

    assert_load_nonzero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int LEN_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             setup_wr,
    input  logic [7:0]       setup_byte,
    input  logic [LEN_W-1:0] setup_len,
    input  logic             conv_wr,
    input  logic             cs_n,
    input  logic             cnvst_n,
    input  logic             chan_temp,
    input  logic             chan_bip_diff,
    input  logic             core_done,
    output logic             core_start,
    output logic             eoc_n,
    output logic [LEN_W-1:0] remaining,
    output logic             scan_active,
    output logic             avg_active,
    output logic             result_twos
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    clk_mode_e        mode_q;
    logic             scan_q, avg_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] len_eff;
    seq_state_e       state_q, state_d;
    logic             cnv_fall;
    logic             trig;
    logic [LEN_W-1:0] run_len;
    logic             go;
    logic             last_done;

    // setup register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= CM_SERIAL;
            scan_q <= 1'b0;
            avg_q  <= 1'b0;
            len_q  <= ONE;
        end else if (setup_wr) begin
            mode_q <= clk_mode_e'(setup_byte[MODE_LSB +: 2]);
            scan_q <= setup_byte[SCAN_BIT];
            avg_q  <= setup_byte[AVG_BIT];
            len_q  <= setup_len;
        end
    end

    assign scan_active = scan_q && (mode_q != CM_EXT_CLK);
    assign avg_active  = avg_q  && (mode_q != CM_EXT_CLK);
    assign len_eff     = (len_q == '0) ? ONE : len_q;

    adc_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (cnvst_n),
        .fall  (cnv_fall)
    );

    // request source and run length by mode
    always_comb begin
        unique case (mode_q)
            CM_PIN_SCAN: begin
                trig    = cnv_fall;
                run_len = scan_active ? len_eff : ONE;
            end
            CM_PIN_SINGLE: begin
                trig    = cnv_fall;
                run_len = ONE;
            end
            CM_SERIAL: begin
                trig    = conv_wr;
                run_len = scan_active ? len_eff : ONE;
            end
            CM_EXT_CLK: begin
                trig    = conv_wr;
                run_len = ONE;
            end
            default: begin
                trig    = 1'b0;
                run_len = ONE;
            end
        endcase
    end

    assign go        = (state_q == ST_IDLE) && trig;
    assign last_done = (state_q == ST_WAIT) && core_done && (remaining == ONE);

    adc_seq_cnt #(.W(LEN_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (go),
        .load_val (run_len),
        .dec      ((state_q == ST_WAIT) && core_done),
        .cnt      (remaining)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (core_done) state_d = (remaining == ONE) ? ST_IDLE : ST_ISSUE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        core_start = (state_q == ST_ISSUE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoc_n       <= 1'b1;
            result_twos <= 1'b0;
        end else begin
            if (mode_q == CM_EXT_CLK || !cs_n || cnv_fall || go)
                eoc_n <= 1'b1;
            else if (last_done)
                eoc_n <= 1'b0;
            if (state_q == ST_ISSUE)
                result_twos <= chan_temp | chan_bip_diff;
        end
    end

    assert_eoc_only_when_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !eoc_n |-> (remaining == '0));

    assert_eoc_high_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == CM_EXT_CLK) |=> eoc_n);

    assert_cs_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |=> eoc_n);

    assert_start_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start);

    assert_start_has_work_R9: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> (remaining != '0));

endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
    localparam int LEN_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             setup_wr = 1'b0;
    logic [7:0]       setup_byte = '0;
    logic [LEN_W-1:0] setup_len = '0;
    logic             conv_wr = 1'b0;
    logic             cs_n = 1'b1;
    logic             cnvst_n = 1'b1;
    logic             chan_temp = 1'b0;
    logic             chan_bip_diff = 1'b0;
    logic             core_done;
    logic             core_start, eoc_n, scan_active, avg_active, result_twos;
    logic [LEN_W-1:0] remaining;

    int total = 0;
    int bad = 0;
    int n_starts = 0;
    int dly = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    adc_seq_ctrl #(.LEN_W(LEN_W)) u_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .setup_wr(setup_wr), .setup_byte(setup_byte),
        .setup_len(setup_len), .conv_wr(conv_wr), .cs_n(cs_n), .cnvst_n(cnvst_n),
        .chan_temp(chan_temp), .chan_bip_diff(chan_bip_diff), .core_done(core_done),
        .core_start(core_start), .eoc_n(eoc_n), .remaining(remaining),
        .scan_active(scan_active), .avg_active(avg_active), .result_twos(result_twos)
    );

    // behavioural SAR core: done three cycles after a start
    always @(posedge clk) begin
        if (!rst_n) begin
            core_done <= 1'b0;
            dly       <= 0;
        end else begin
            core_done <= 1'b0;
            if (dly > 0) begin
                dly <= dly - 1;
                if (dly == 1) core_done <= 1'b1;
            end
            if (core_start) begin
                dly      <= 3;
                n_starts <= n_starts + 1;
            end
        end
    end

    function automatic int exp_ops(input logic [1:0] m, input bit sc, input int len);
        if (m == 2'b01 || m == 2'b11) return 1;
        if (!sc) return 1;
        return (len == 0) ? 1 : len;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_setup(input logic [1:0] m, input bit sc, input bit av,
                            input int len, input logic [3:0] junk);
        @(negedge clk);
        setup_wr   = 1'b1;
        setup_byte = {junk[3:2], m, sc, av, junk[1:0]};
        setup_len  = LEN_W'(len);
        @(negedge clk);
        setup_wr = 1'b0;
    endtask

    task automatic pulse_cnv();
        @(negedge clk);
        cnvst_n = 1'b0;
        repeat (4) @(negedge clk);
        cnvst_n = 1'b1;
    endtask

    task automatic pulse_wr();
        @(negedge clk);
        conv_wr = 1'b1;
        @(negedge clk);
        conv_wr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400; i++) begin
            if (remaining == '0) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int s0;
        int seed;
        bit early_low;
        seed = $urandom(1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(eoc_n == 1'b1, "R1 eoc_n", eoc_n, 1);
        chk(remaining == '0, "R1 remaining", remaining, 0);
        chk(core_start == 1'b0, "R1 core_start", core_start, 0);
        chk(scan_active == 1'b0, "R1 scan_active", scan_active, 0);
        s0 = n_starts;
        pulse_wr();
        wait_idle();
        chk(n_starts - s0 == 1, "R1 default mode start count", n_starts - s0, 1);
        chk(eoc_n == 1'b0, "R1 default mode eoc_n", eoc_n, 0);

        // R8 cs_n low releases eoc
        @(negedge clk); cs_n = 1'b0;
        @(negedge clk); cs_n = 1'b1;
        chk(eoc_n == 1'b1, "R8 cs_n release", eoc_n, 1);

        // R3 scan of 3 in mode 00, eoc high until the end
        do_setup(2'b00, 1, 0, 3, 4'h0);
        s0 = n_starts;
        pulse_cnv();
        early_low = 0;
        for (int i = 0; i < 400; i++) begin
            if (remaining == '0) break;
            if (eoc_n == 1'b0) early_low = 1;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
        chk(!early_low, "R3 eoc_n mid-scan", int'(early_low), 0);
        chk(n_starts - s0 == 3, "R3 scan start count", n_starts - s0, 3);
        chk(eoc_n == 1'b0, "R3 eoc_n after scan", eoc_n, 0);

        // R7 retrigger while busy
        do_setup(2'b00, 1, 0, 5, 4'h0);
        s0 = n_starts;
        pulse_cnv();
        pulse_cnv();
        wait_idle();
        chk(n_starts - s0 == 5, "R7 busy retrigger", n_starts - s0, 5);

        // R8 + R7: cnv edge in mode 10 raises eoc, starts nothing
        do_setup(2'b10, 0, 0, 1, 4'h0);
        pulse_wr();
        wait_idle();
        s0 = n_starts;
        pulse_cnv();
        repeat (6) @(negedge clk);
        chk(eoc_n == 1'b1, "R8 cnv edge release", eoc_n, 1);
        chk(n_starts == s0, "R7 cnv ignored in mode 10", n_starts - s0, 0);

        // R9 remaining loaded
        do_setup(2'b10, 1, 0, 4, 4'h0);
        pulse_wr();
        chk(remaining == 4'd4, "R9 remaining load", remaining, 4);
        wait_idle();

        // R11 zero length
        do_setup(2'b10, 1, 0, 0, 4'h0);
        s0 = n_starts;
        pulse_wr();
        wait_idle();
        chk(n_starts - s0 == 1, "R11 zero length", n_starts - s0, 1);

        // R6 gating, R2 bit fields
        do_setup(2'b10, 1, 1, 2, 4'h0);
        chk(scan_active && avg_active, "R2 scan/avg set", {scan_active, avg_active}, 3);
        do_setup(2'b11, 1, 1, 2, 4'hF);
        chk(!scan_active && !avg_active, "R6 scan/avg gated", {scan_active, avg_active}, 0);
        @(negedge clk);
        chk(eoc_n == 1'b1, "R6 eoc_n high", eoc_n, 1);

        // R10 format flag
        do_setup(2'b10, 0, 0, 1, 4'h0);
        chan_temp = 1'b1; pulse_wr(); wait_idle();
        chk(result_twos == 1'b1, "R10 temp twos", result_twos, 1);
        chan_temp = 1'b0; chan_bip_diff = 1'b1; pulse_wr(); wait_idle();
        chk(result_twos == 1'b1, "R10 bipolar twos", result_twos, 1);
        chan_bip_diff = 1'b0; pulse_wr(); wait_idle();
        chk(result_twos == 1'b0, "R10 binary", result_twos, 0);

        // random mix: R2 R3 R4 R5 R6 R7
        for (int it = 0; it < 40; it++) begin
            logic [1:0] m;
            bit sc;
            int len;
            logic [3:0] junk;
            m    = 2'($urandom_range(0, 3));
            sc   = 1'($urandom_range(0, 1));
            len  = $urandom_range(0, 6);
            junk = 4'($urandom_range(0, 15));
            do_setup(m, sc, 1'($urandom_range(0, 1)), len, junk);
            s0 = n_starts;
            if (m[1]) pulse_cnv(); else pulse_wr();
            repeat (6) @(negedge clk);
            chk(n_starts == s0, "R7 wrong source ignored", n_starts - s0, 0);
            s0 = n_starts;
            if (m[1]) pulse_wr(); else pulse_cnv();
            wait_idle();
            chk(n_starts - s0 == exp_ops(m, sc, len), "R2 R3 R4 R5 start count",
                n_starts - s0, exp_ops(m, sc, len));
            chk(eoc_n == (m == 2'b11), "R4 R5 R6 eoc_n after run", eoc_n, int'(m == 2'b11));
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule